// File: doc/BRIEF.md
# FP/SIMD Access Permission Checker

This block decides, for every floating-point or vector instruction and every access to a floating-point system register, whether execution may go ahead or which exception must be raised instead. It works for a processor whose privilege levels can each run in 32-bit or 64-bit mode. Its inputs are the current level, the security state, the width of the higher levels, and flags that say whether virtualization and security are present. It also takes the control fields that gate the floating-point unit: the per-level enables, the vector-disable bits, the non-secure override grants, the hypervisor and upper-level trap bits, and the unit-enable bit.

The decision is purely combinational. The checks run in a fixed order and only the first one that fails is reported. That fault is given as a kind, a target level, an exception class and a syndrome. A decode stage places the block beside the instruction decoder and feeds the result to exception entry. No state is held.

A control part walks the priority chain and hands a small strobe struct to a datapath part. The datapath turns the selected fault into the encoded output fields.

Top module: `fp_simd_perm_check`

## Requirements
- R1: When the current level is 0 and level 1 is 64-bit, `fpEnField` must equal 2'b11. Any other value gives a supervisor trap (kind 2) to level 1 with syndrome 0x1E00000 and class `CLS_FP` (default 0x07).
- R2: On the 64-bit route, once R1 passes, two further checks run in this order. First, `cptr2Tfp` set with virtualization present and level at most 2 gives a hypervisor trap (kind 3) to level 2. Second, `cptr3Tfp` set with security present gives a monitor trap (kind 4) to level 3. Both use syndrome 0x1E00000 and class `CLS_FP`.
- R3: Kind encoding: 0 none, 1 disabled, 2 supervisor trap, 3 hypervisor trap, 4 monitor trap, 5 undefined-with-syndrome. `faultValid` is 1 exactly when the kind is not 0. With no fault, every other field is 0. A disabled fault has class 0 and syndrome 0, and targets level 1 from levels 0 and 1, otherwise the current level.
- R4: On the 32-bit route, overrides apply when security is present, level 3 is 32-bit and the state is non-secure. A set `nsSimdDis` makes the vector-disable effective. A clear `nsCp10Grant` makes the effective 2-bit cp10 enable zero.
- R5: Outside level 2, a disabled fault is raised in two cases. The first is a vector request while the effective vector-disable is set. The second is a failed cp10 check: level 0 needs 2'b11, and other levels need bit 0. At level 2 neither check applies.
- R6: When the effective unit-enable check is on and `fpexcEn` is 0, a disabled fault is raised.
- R7: In non-secure state with virtualization present and level 2 64-bit, the R2 trap checks run in place of the 32-bit hypervisor bits. The 32-bit hypervisor bits are then ignored.
- R8: In non-secure state with virtualization present and level 2 32-bit, a hypervisor trap fires in two cases: a vector request with the vector-trap bit set, or the cp10 trap bit set. Under the R4 conditions, `nsSimdDis` forces the vector-trap bit on and a clear `nsCp10Grant` forces the cp10 trap bit on. The syndrome is 0x20 for a vector request and 0xA otherwise, and the class is `CLS_HYPCP` (default 0x07). At level 2 the kind is 5; below level 2 it is 3. The target is level 2 in both cases.
- R9: Last, with security present and level 3 64-bit, a set `cptr3Tfp` gives a monitor trap to level 3 with syndrome 0x1E00000.
- R10: A status/control register move (`reqSysReg`=1, `reqStatusReg`=1) always runs with the unit-enable check on. Any other system register gives a disabled fault from level 0; from levels 1 to 3 it runs with the unit-enable check off. A plain instruction (`reqSysReg`=0) follows `reqFpEnChk`.
- R11: Only the first failing check in the order R10 (unprivileged system register), R1, R2, R5, R6, R7, R8, R9 is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| curLvl | input | 2 | Current privilege level 0..3 |
| nonSecure | input | 1 | 1 when executing in non-secure state |
| el1Is64 | input | 1 | Level 1 runs 64-bit |
| el2Is64 | input | 1 | Level 2 runs 64-bit |
| el3Is64 | input | 1 | Level 3 runs 64-bit |
| hasVirt | input | 1 | Virtualization is implemented |
| hasSec | input | 1 | Security is implemented |
| fpEnField | input | 2 | 64-bit level-1 FP enable field |
| cpacrCp10 | input | 2 | 32-bit cp10 access enable |
| cpacrSimdDis | input | 1 | 32-bit vector-disable bit |
| nsCp10Grant | input | 1 | Non-secure cp10 access grant |
| nsSimdDis | input | 1 | Non-secure vector-disable override |
| hypCp10Trap | input | 1 | 32-bit hypervisor cp10 trap bit |
| hypSimdTrap | input | 1 | 32-bit hypervisor vector trap bit |
| cptr2Tfp | input | 1 | 64-bit level-2 FP trap bit |
| cptr3Tfp | input | 1 | 64-bit level-3 FP trap bit |
| fpexcEn | input | 1 | Floating-point unit enable bit |
| reqSimd | input | 1 | Request is a vector operation |
| reqFpEnChk | input | 1 | Plain instruction asks for the unit-enable check |
| reqSysReg | input | 1 | Request is an FP system register access |
| reqStatusReg | input | 1 | That register is the status/control register |
| faultValid | output | 1 | A fault is raised |
| faultKind | output | 3 | Fault kind per R3 |
| faultLvl | output | 2 | Target level |
| excClass | output | 6 | Exception class |
| syndrome | output | 25 | Syndrome value |

## Verification
Several checks can fail on the same request, and the hard part is showing that the earlier one in the chain wins. The bench sets two failing conditions at once: a cleared cp10 enable together with a hypervisor cp10 trap, level-2 and level-3 64-bit trap bits together, and an unprivileged system register access while every enable is open. It then judges that only the higher-priority fault appears, with that fault's own target, class and syndrome. A second clash is between the 32-bit hypervisor bits and a 64-bit level 2; it is provoked by setting both, and the bench expects the 32-bit bits to be ignored.

// File: rtl/fpperm_pkg.sv
package fpperm_pkg;

  typedef enum logic [2:0] {
    FK_NONE   = 3'd0,
    FK_DIS    = 3'd1,
    FK_SUP    = 3'd2,
    FK_HYP    = 3'd3,
    FK_MON    = 3'd4,
    FK_UNDSYN = 3'd5
  } faultKind_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIS,
    SEL_T64_EL1,
    SEL_T64_EL2,
    SEL_T64_EL3,
    SEL_HYP32,
    SEL_UND32
  } faultSel_e;

  // strobes from control to datapath
  typedef struct packed {
    faultSel_e   sel;
    logic        simd;
    logic [1:0]  lvl;
  } permStrb_t;

endpackage

// File: rtl/fpperm_ctrl.sv
module fpperm_ctrl
  import fpperm_pkg::*;
(
  input  logic [1:0] curLvl,
  input  logic       nonSecure,
  input  logic       el1Is64,
  input  logic       el2Is64,
  input  logic       el3Is64,
  input  logic       hasVirt,
  input  logic       hasSec,
  input  logic [1:0] fpEnField,
  input  logic [1:0] cpacrCp10,
  input  logic       cpacrSimdDis,
  input  logic       nsCp10Grant,
  input  logic       nsSimdDis,
  input  logic       hypCp10Trap,
  input  logic       hypSimdTrap,
  input  logic       cptr2Tfp,
  input  logic       cptr3Tfp,
  input  logic       fpexcEn,
  input  logic       reqSimd,
  input  logic       reqFpEnChk,
  input  logic       reqSysReg,
  input  logic       reqStatusReg,
  output permStrb_t  strb
);

  logic       privLvl;
  logic       sysOther;
  logic       sysUnpriv;
  logic       effChk;
  logic       path64;
  logic       nsOverride;
  logic       effSimdDis;
  logic [1:0] effCp10;
  logic       cp10Ok;
  logic       t64El2Hit;
  logic       t64El3Hit;
  logic       hypSimdEff;
  logic       hypCp10Eff;
  logic       hypFire;
  logic       notHypLvl;

  assign privLvl    = (curLvl != 2'd0);
  assign sysOther   = reqSysReg && !reqStatusReg;
  assign sysUnpriv  = sysOther && !privLvl;
  assign effChk     = reqSysReg ? reqStatusReg : reqFpEnChk;
  assign path64     = (curLvl == 2'd0) && el1Is64;
  assign notHypLvl  = (curLvl != 2'd2);

  // non-secure rewrite of the effective enables
  assign nsOverride = hasSec && !el3Is64 && nonSecure;
  assign effSimdDis = cpacrSimdDis || (nsOverride && nsSimdDis);
  assign effCp10    = (nsOverride && !nsCp10Grant) ? 2'b00 : cpacrCp10;
  assign cp10Ok     = (curLvl == 2'd0) ? (effCp10 == 2'b11) : effCp10[0];

  // upper-level 64-bit trap bits
  assign t64El2Hit  = hasVirt && (curLvl <= 2'd2) && cptr2Tfp;
  assign t64El3Hit  = hasSec && cptr3Tfp;

  // 32-bit hypervisor trap bits with forced view
  assign hypSimdEff = hypSimdTrap || (nsOverride && nsSimdDis);
  assign hypCp10Eff = hypCp10Trap || (nsOverride && !nsCp10Grant);
  assign hypFire    = (reqSimd && hypSimdEff) || hypCp10Eff;

  always_comb begin
    strb.sel  = SEL_NONE;
    strb.simd = reqSimd;
    strb.lvl  = curLvl;
    if (sysUnpriv) begin
      strb.sel = SEL_DIS;
    end else if (path64) begin
      if (fpEnField != 2'b11)  strb.sel = SEL_T64_EL1;
      else if (t64El2Hit)      strb.sel = SEL_T64_EL2;
      else if (t64El3Hit)      strb.sel = SEL_T64_EL3;
    end else if (notHypLvl && reqSimd && effSimdDis) begin
      strb.sel = SEL_DIS;
    end else if (notHypLvl && !cp10Ok) begin
      strb.sel = SEL_DIS;
    end else if (effChk && !fpexcEn) begin
      strb.sel = SEL_DIS;
    end else if (hasVirt && nonSecure && el2Is64) begin
      if (t64El2Hit)           strb.sel = SEL_T64_EL2;
      else if (t64El3Hit)      strb.sel = SEL_T64_EL3;
    end else if (hasVirt && nonSecure && hypFire) begin
      strb.sel = (curLvl == 2'd2) ? SEL_UND32 : SEL_HYP32;
    end else if (hasSec && el3Is64 && cptr3Tfp) begin
      strb.sel = SEL_T64_EL3;
    end
  end

  // an unprivileged access to a non-status FP register never passes
  always_comb begin
    if (sysUnpriv)
      p_sysreg_unpriv_r10: assert (strb.sel == SEL_DIS)
        else $error("unprivileged system register access not refused");
  end

  // 64-bit route at level 0 with an incomplete enable goes to level 1
  always_comb begin
    if (!sysUnpriv && path64 && fpEnField != 2'b11)
      p_el0_enable_r1: assert (strb.sel == SEL_T64_EL1)
        else $error("level-0 64-bit enable failure not trapped to level 1");
  end

endmodule

// File: rtl/fpperm_dp.sv
module fpperm_dp
  import fpperm_pkg::*;
#(
  parameter int          SYN_W     = 25,
  parameter int          CLS_W     = 6,
  parameter logic [5:0]  CLS_FP    = 6'h07,
  parameter logic [5:0]  CLS_HYPCP = 6'h07
) (
  input  permStrb_t          strb,
  output logic               faultValid,
  output logic [2:0]         faultKind,
  output logic [1:0]         faultLvl,
  output logic [CLS_W-1:0]   excClass,
  output logic [SYN_W-1:0]   syndrome
);

  localparam logic [SYN_W-1:0] SYN_T64  = SYN_W'(32'h01E0_0000);
  localparam logic [SYN_W-1:0] SYN_VEC  = SYN_W'(32'h20);
  localparam logic [SYN_W-1:0] SYN_CP10 = SYN_W'(32'h0A);

  faultKind_e       kind;
  logic [SYN_W-1:0] hypSyn;
  logic [1:0]       disLvl;

  assign hypSyn = strb.simd ? SYN_VEC : SYN_CP10;
  assign disLvl = (strb.lvl[1] == 1'b0) ? 2'd1 : strb.lvl;

  always_comb begin
    kind     = FK_NONE;
    faultLvl = 2'd0;
    excClass = '0;
    syndrome = '0;
    unique case (strb.sel)
      SEL_DIS: begin
        kind     = FK_DIS;
        faultLvl = disLvl;
      end
      SEL_T64_EL1: begin
        kind     = FK_SUP;
        faultLvl = 2'd1;
        excClass = CLS_W'(CLS_FP);
        syndrome = SYN_T64;
      end
      SEL_T64_EL2: begin
        kind     = FK_HYP;
        faultLvl = 2'd2;
        excClass = CLS_W'(CLS_FP);
        syndrome = SYN_T64;
      end
      SEL_T64_EL3: begin
        kind     = FK_MON;
        faultLvl = 2'd3;
        excClass = CLS_W'(CLS_FP);
        syndrome = SYN_T64;
      end
      SEL_HYP32: begin
        kind     = FK_HYP;
        faultLvl = 2'd2;
        excClass = CLS_W'(CLS_HYPCP);
        syndrome = hypSyn;
      end
      SEL_UND32: begin
        kind     = FK_UNDSYN;
        faultLvl = 2'd2;
        excClass = CLS_W'(CLS_HYPCP);
        syndrome = hypSyn;
      end
      default: ;
    endcase
  end

  assign faultKind  = kind;
  assign faultValid = (kind != FK_NONE);

  // a hypervisor-kind fault always lands at level 2
  always_comb begin
    if (strb.sel == SEL_HYP32 || strb.sel == SEL_UND32)
      p_hyp_target_r8: assert (faultLvl == 2'd2 && (syndrome == SYN_VEC || syndrome == SYN_CP10))
        else $error("32-bit hypervisor trap mis-encoded");
  end

endmodule

// File: rtl/fp_simd_perm_check.sv
module fp_simd_perm_check
  import fpperm_pkg::*;
#(
  parameter int         SYN_W     = 25,
  parameter int         CLS_W     = 6,
  parameter logic [5:0] CLS_FP    = 6'h07,
  parameter logic [5:0] CLS_HYPCP = 6'h07
) (
  input  logic [1:0]       curLvl,
  input  logic             nonSecure,
  input  logic             el1Is64,
  input  logic             el2Is64,
  input  logic             el3Is64,
  input  logic             hasVirt,
  input  logic             hasSec,
  input  logic [1:0]       fpEnField,
  input  logic [1:0]       cpacrCp10,
  input  logic             cpacrSimdDis,
  input  logic             nsCp10Grant,
  input  logic             nsSimdDis,
  input  logic             hypCp10Trap,
  input  logic             hypSimdTrap,
  input  logic             cptr2Tfp,
  input  logic             cptr3Tfp,
  input  logic             fpexcEn,
  input  logic             reqSimd,
  input  logic             reqFpEnChk,
  input  logic             reqSysReg,
  input  logic             reqStatusReg,
  output logic             faultValid,
  output logic [2:0]       faultKind,
  output logic [1:0]       faultLvl,
  output logic [CLS_W-1:0] excClass,
  output logic [SYN_W-1:0] syndrome
);

  permStrb_t strb;

  fpperm_ctrl u_ctrl (
    .curLvl      (curLvl),
    .nonSecure   (nonSecure),
    .el1Is64     (el1Is64),
    .el2Is64     (el2Is64),
    .el3Is64     (el3Is64),
    .hasVirt     (hasVirt),
    .hasSec      (hasSec),
    .fpEnField   (fpEnField),
    .cpacrCp10   (cpacrCp10),
    .cpacrSimdDis(cpacrSimdDis),
    .nsCp10Grant (nsCp10Grant),
    .nsSimdDis   (nsSimdDis),
    .hypCp10Trap (hypCp10Trap),
    .hypSimdTrap (hypSimdTrap),
    .cptr2Tfp    (cptr2Tfp),
    .cptr3Tfp    (cptr3Tfp),
    .fpexcEn     (fpexcEn),
    .reqSimd     (reqSimd),
    .reqFpEnChk  (reqFpEnChk),
    .reqSysReg   (reqSysReg),
    .reqStatusReg(reqStatusReg),
    .strb        (strb)
  );

  fpperm_dp #(
    .SYN_W    (SYN_W),
    .CLS_W    (CLS_W),
    .CLS_FP   (CLS_FP),
    .CLS_HYPCP(CLS_HYPCP)
  ) u_dp (
    .strb      (strb),
    .faultValid(faultValid),
    .faultKind (faultKind),
    .faultLvl  (faultLvl),
    .excClass  (excClass),
    .syndrome  (syndrome)
  );

  // no fault means quiet outputs
  always_comb begin
    if (!faultValid)
      p_quiet_none_r3: assert (faultKind == 3'd0 && faultLvl == 2'd0 && syndrome == '0)
        else $error("no-fault outputs not zero");
  end

  // a 32-bit request with the unit check on and the unit off is refused
  always_comb begin
    if (curLvl != 2'd0 && !reqSysReg && reqFpEnChk && !fpexcEn)
      p_unit_off_r6: assert (faultValid && faultKind == 3'd1)
        else $error("unit-enable failure not reported as disabled");
  end

  // 64-bit upper-level traps carry the fixed syndrome
  always_comb begin
    if (faultKind == 3'd2 || faultKind == 3'd4)
      p_t64_syndrome_r2: assert (syndrome == SYN_W'(32'h01E0_0000))
        else $error("64-bit trap syndrome wrong");
  end

endmodule

// File: tb/sim_fp_simd_perm_check.sv
module sim_fp_simd_perm_check;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]  curLvl;
  logic        nonSecure, el1Is64, el2Is64, el3Is64, hasVirt, hasSec;
  logic [1:0]  fpEnField, cpacrCp10;
  logic        cpacrSimdDis, nsCp10Grant, nsSimdDis, hypCp10Trap, hypSimdTrap;
  logic        cptr2Tfp, cptr3Tfp, fpexcEn, reqSimd, reqFpEnChk, reqSysReg, reqStatusReg;
  logic        faultValid;
  logic [2:0]  faultKind;
  logic [1:0]  faultLvl;
  logic [5:0]  excClass;
  logic [24:0] syndrome;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  localparam int S64 = 32'h01E0_0000;

  fp_simd_perm_check u0 (.*);

  task automatic setBase();
    curLvl = 2'd1; nonSecure = 1'b1; el1Is64 = 1'b0; el2Is64 = 1'b0; el3Is64 = 1'b0;
    hasVirt = 1'b1; hasSec = 1'b1; fpEnField = 2'b11; cpacrCp10 = 2'b11;
    cpacrSimdDis = 1'b0; nsCp10Grant = 1'b1; nsSimdDis = 1'b0;
    hypCp10Trap = 1'b0; hypSimdTrap = 1'b0; cptr2Tfp = 1'b0; cptr3Tfp = 1'b0;
    fpexcEn = 1'b1; reqSimd = 1'b0; reqFpEnChk = 1'b1; reqSysReg = 1'b0; reqStatusReg = 1'b0;
  endtask

  task automatic expectF(string tag, int k, int l, int c, int s);
    @(negedge clk);
    #1;
    total++;
    if (faultValid !== (k != 0) || faultKind !== 3'(k) || faultLvl !== 2'(l) ||
        excClass !== 6'(c) || syndrome !== 25'(s)) begin
      bad++;
      $display("FAIL %s: got v=%0b k=%0d l=%0d c=%0h s=%0h exp v=%0b k=%0d l=%0d c=%0h s=%0h",
               tag, faultValid, faultKind, faultLvl, excClass, syndrome,
               (k != 0), k, l, c, s);
    end
  endtask

  task automatic tBase();
    setBase(); expectF("R3 baseline no fault", 0, 0, 0, 0);
    curLvl = 2'd0; expectF("R3 level0 open", 0, 0, 0, 0);
  endtask

  task automatic tEl0Sixty4();
    setBase(); curLvl = 2'd0; el1Is64 = 1'b1; fpEnField = 2'b01;
    expectF("R1 el0 partial enable", 2, 1, 7, S64);
    fpEnField = 2'b10; expectF("R1 el0 bit1 only", 2, 1, 7, S64);
    fpEnField = 2'b11; cpacrCp10 = 2'b00; fpexcEn = 1'b0;
    expectF("R1 64-bit route ignores 32-bit fields", 0, 0, 0, 0);
  endtask

  task automatic tUpper64();
    setBase(); curLvl = 2'd0; el1Is64 = 1'b1; cptr2Tfp = 1'b1;
    expectF("R2 level2 trap", 3, 2, 7, S64);
    cptr3Tfp = 1'b1; expectF("R11 level2 before level3", 3, 2, 7, S64);
    hasVirt = 1'b0; expectF("R2 level3 trap without virt", 4, 3, 7, S64);
    hasSec = 1'b0; expectF("R2 no security no trap", 0, 0, 0, 0);
    setBase(); curLvl = 2'd0; el1Is64 = 1'b1; fpEnField = 2'b00; cptr2Tfp = 1'b1;
    expectF("R11 enable before level2", 2, 1, 7, S64);
  endtask

  task automatic tCpacr();
    setBase(); reqSimd = 1'b1; cpacrSimdDis = 1'b1;
    expectF("R5 vector disabled", 1, 1, 0, 0);
    reqSimd = 1'b0; expectF("R5 scalar passes vector disable", 0, 0, 0, 0);
    cpacrSimdDis = 1'b0; cpacrCp10 = 2'b10; expectF("R5 cp10 bit0 clear", 1, 1, 0, 0);
    cpacrCp10 = 2'b01; expectF("R5 cp10 privileged ok", 0, 0, 0, 0);
    curLvl = 2'd0; expectF("R5 cp10 level0 needs 11", 1, 1, 0, 0);
    curLvl = 2'd2; cpacrCp10 = 2'b00; cpacrSimdDis = 1'b1; reqSimd = 1'b1;
    expectF("R5 level2 exempt", 0, 0, 0, 0);
    nonSecure = 1'b0; curLvl = 2'd3; cpacrCp10 = 2'b11;
    expectF("R3 disabled target level3", 1, 3, 0, 0);
  endtask

  task automatic tOverride();
    setBase(); reqSimd = 1'b1; nsSimdDis = 1'b1; hasVirt = 1'b0;
    expectF("R4 ns vector override", 1, 1, 0, 0);
    nonSecure = 1'b0; expectF("R4 secure ignores override", 0, 0, 0, 0);
    setBase(); nsCp10Grant = 1'b0;
    expectF("R4 ns cp10 grant cleared", 1, 1, 0, 0);
    el3Is64 = 1'b1; expectF("R4 64-bit level3 no override", 0, 0, 0, 0);
  endtask

  task automatic tUnitEn();
    setBase(); fpexcEn = 1'b0;
    expectF("R6 unit disabled", 1, 1, 0, 0);
    reqFpEnChk = 1'b0; expectF("R6 check off passes", 0, 0, 0, 0);
    reqFpEnChk = 1'b1; curLvl = 2'd2; expectF("R6 level2 disabled target", 1, 2, 0, 0);
  endtask

  task automatic tHyp32();
    setBase(); hypCp10Trap = 1'b1;
    expectF("R8 cp10 hyp trap", 3, 2, 7, 32'hA);
    reqSimd = 1'b1; expectF("R8 vector syndrome", 3, 2, 7, 32'h20);
    hypCp10Trap = 1'b0; hypSimdTrap = 1'b1; reqSimd = 1'b0;
    expectF("R8 vector trap ignores scalar", 0, 0, 0, 0);
    reqSimd = 1'b1; expectF("R8 vector trap", 3, 2, 7, 32'h20);
    curLvl = 2'd2; expectF("R8 level2 undefined with syndrome", 5, 2, 7, 32'h20);
    setBase(); curLvl = 2'd2; nsCp10Grant = 1'b0;
    expectF("R8 forced cp10 trap at level2", 5, 2, 7, 32'hA);
    setBase(); curLvl = 2'd2; nsSimdDis = 1'b1; reqSimd = 1'b1;
    expectF("R8 forced vector trap at level2", 5, 2, 7, 32'h20);
    setBase(); hypCp10Trap = 1'b1; nonSecure = 1'b0;
    expectF("R8 secure skips hyp bits", 0, 0, 0, 0);
  endtask

  task automatic tEl2Sixty4();
    setBase(); el2Is64 = 1'b1; cptr2Tfp = 1'b1;
    expectF("R7 64-bit level2 trap", 3, 2, 7, S64);
    cptr2Tfp = 1'b0; hypCp10Trap = 1'b1; hypSimdTrap = 1'b1; reqSimd = 1'b1;
    expectF("R7 32-bit hyp bits ignored", 0, 0, 0, 0);
    cptr3Tfp = 1'b1; expectF("R7 level3 trap via 64-bit level2", 4, 3, 7, S64);
  endtask

  task automatic tEl3Final();
    setBase(); nonSecure = 1'b0; el3Is64 = 1'b1; cptr3Tfp = 1'b1;
    expectF("R9 final level3 trap", 4, 3, 7, S64);
    el3Is64 = 1'b0; expectF("R9 32-bit level3 no trap", 0, 0, 0, 0);
  endtask

  task automatic tSysReg();
    setBase(); curLvl = 2'd0; reqSysReg = 1'b1;
    expectF("R10 unprivileged sysreg", 1, 1, 0, 0);
    el1Is64 = 1'b1; expectF("R11 sysreg before 64-bit route", 1, 1, 0, 0);
    setBase(); reqSysReg = 1'b1; fpexcEn = 1'b0;
    expectF("R10 privileged sysreg skips unit check", 0, 0, 0, 0);
    reqStatusReg = 1'b1; reqFpEnChk = 1'b0;
    expectF("R10 status reg forces unit check", 1, 1, 0, 0);
    setBase(); curLvl = 2'd0; reqSysReg = 1'b1; reqStatusReg = 1'b1;
    expectF("R10 status reg from level0 allowed", 0, 0, 0, 0);
  endtask

  task automatic tPriority();
    setBase(); cpacrCp10 = 2'b00; hypCp10Trap = 1'b1;
    expectF("R11 cp10 before hyp trap", 1, 1, 0, 0);
    setBase(); fpexcEn = 1'b0; hypCp10Trap = 1'b1;
    expectF("R11 unit before hyp trap", 1, 1, 0, 0);
  endtask

  initial begin
    setBase();
    tBase();
    tEl0Sixty4();
    tUpper64();
    tCpacr();
    tOverride();
    tUnitEn();
    tHyp32();
    tEl2Sixty4();
    tEl3Final();
    tSysReg();
    tPriority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: got running exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule